// File: doc/BRIEF.md
# Key-Guarded Clock Source Selector

This block holds the clock-source setting of a chip behind a three-step unlock on a simple memory-mapped write bus. The bus carries an address, a data byte and a write strobe. A combinational read port returns the stored setting. The stored setting has two parts: a two-bit oscillator code and an enable for an external clock pin. Both are driven out continuously, together with a decoded flag that shows whether the external crystal is selected.

The register changes only through this ordered series of bus writes: an opening key to one address, the new setting to the guarded address, and a closing key to a third address. Cycles with no write may fall between these steps. The setting carried by the middle write is staged and does not take effect until the closing key arrives on the next bus write. If any step fails, the sequence is abandoned, the staged value is dropped, and a one-cycle error pulse is raised.

Top module: `keyed_clk_cfg`

## Requirements
- R1: After reset the stored setting is 0, the oscillator code, external enable, crystal flag and error flag are all low, and a read of the guarded address returns 0x00.
- R2: A write to the guarded address (default 0x24) changes nothing unless the bus write just before it put 0xAA into the opening key address (default 0x20). A guarded write that lacks this opening key raises the error flag.
- R3: A staged setting takes effect only on the write of 0x55 to the closing key address (default 0x28). The outputs show the new setting in the cycle after that write.
- R4: While a sequence is under way, any bus write that is not the expected next step abandons it. This includes a wrong key value and a write to any other address. The staged value is dropped and the stored setting keeps its old value.
- R5: Each abandoned sequence or rejected write raises the error flag for exactly the one cycle after the offending write, and the flag is low whenever no such write occurred.
- R6: Bits 7:3 of the guarded register are ignored on write and always read as 0.
- R7: Bit 2 of the stored setting drives the external clock enable: 1 enables it and 0 disables it.
- R8: Bits 1:0 drive the oscillator code. The crystal flag is high only for code 2'b10. Codes 00, 01 and 11 select the internal 32,768 Hz oscillator, and the flag is low for them.
- R9: A read (rd_en high) of the guarded address returns the stored setting in bits 2:0. A read of either key address, of any other address, or with rd_en low returns 0.
- R10: Cycles with wr_en low between the steps of a sequence neither break nor advance it.
- R11: With no sequence under way, writes to addresses other than the two keys and the guarded register have no effect and raise no error.
- R12: With no sequence under way, a write of a wrong value to the opening key, or any write to the closing key, raises the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read enable |
| addr | input | ADDR_W (8) | Bus address |
| wdata | input | DATA_W (8) | Bus write data |
| rdata | output | DATA_W (8) | Read data, combinational from addr and rd_en |
| osc_sel | output | 2 | Stored oscillator code |
| ext_clk_en | output | 1 | External clock input enable |
| xtal_sel | output | 1 | High when the external crystal is selected |
| seq_err | output | 1 | One-cycle pulse after a rejected or aborting write |

## Verification
The assertions check several rules on every cycle:
- the outputs stay unchanged unless the previous cycle held a correct closing key write;
- an abort never changes the setting;
- reserved bits read zero, readback agrees with the outputs, and key addresses read zero;
- an error only follows a write, and an unkeyed guarded write always flags.

Some behaviour appears only in the bench scenarios. These include gaps of idle cycles inside a sequence, back-to-back sequences, and the dropping of a staged value followed by a later stray closing key. They also include the full decode of each oscillator code. The reference model tracks all of these cycle by cycle.

// File: rtl/kcg_pkg.sv
package kcg_pkg;

    // unlock progress
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_PEND  = 2'd2
    } seq_e;

    // width of the live part of the guarded register
    localparam int CFG_W = 3;

    // stored setting: bit 2 external enable, bits 1:0 oscillator code
    typedef struct packed {
        logic       ext_en;
        logic [1:0] osc;
    } cfg_t;

    localparam logic [1:0] OSC_XTAL = 2'b10;

endpackage

// File: rtl/kcg_decode.sv
module kcg_decode #(
    parameter int               ADDR_W     = 8,
    parameter int               DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h24,
    parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'h28,
    parameter logic [DATA_W-1:0] KEY_A_VAL  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_B_VAL  = 8'h55
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sel_key_a,
    output logic              sel_cfg,
    output logic              sel_key_b,
    output logic              key_a_ok,
    output logic              key_b_ok
);

    always_comb begin
        sel_key_a = (addr == KEY_A_ADDR);
        sel_cfg   = (addr == CFG_ADDR);
        sel_key_b = (addr == KEY_B_ADDR);
        key_a_ok  = (wdata == KEY_A_VAL);
        key_b_ok  = (wdata == KEY_B_VAL);
    end

endmodule

// File: rtl/kcg_seq.sv
module kcg_seq
    import kcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic sel_key_a,
    input  logic sel_cfg,
    input  logic sel_key_b,
    input  logic key_a_ok,
    input  logic key_b_ok,
    output logic stage_en,
    output logic commit_en,
    output logic drop_en,
    output logic err_o
);

    typedef struct packed {
        seq_e state;
        logic err;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        stage_en  = 1'b0;
        commit_en = 1'b0;
        if (wr_en) begin
            unique case (st_q.state)
                SEQ_IDLE: begin
                    if (sel_key_a) begin
                        if (key_a_ok) st_d.state = SEQ_ARMED;
                        else          st_d.err   = 1'b1;
                    end else if (sel_cfg || sel_key_b) begin
                        st_d.err = 1'b1;
                    end
                end
                SEQ_ARMED: begin
                    if (sel_cfg) begin
                        stage_en   = 1'b1;
                        st_d.state = SEQ_PEND;
                    end else begin
                        st_d.err   = 1'b1;
                        st_d.state = SEQ_IDLE;
                    end
                end
                SEQ_PEND: begin
                    if (sel_key_b && key_b_ok) commit_en = 1'b1;
                    else                       st_d.err  = 1'b1;
                    st_d.state = SEQ_IDLE;
                end
                default: st_d.state = SEQ_IDLE;
            endcase
        end
        drop_en = st_d.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: SEQ_IDLE, err: 1'b0};
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    // R2: guarded write without a preceding opening key is flagged
    p_unkeyed_cfg_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_cfg && st_q.state != SEQ_ARMED) |=> err_o);

    // R5: an error pulse only follows a bus write
    p_err_follows_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(wr_en));

endmodule

// File: rtl/kcg_store.sv
module kcg_store
    import kcg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_en,
    input  logic              commit_en,
    input  logic              drop_en,
    input  logic [CFG_W-1:0]  wcfg,
    input  logic              rd_en,
    input  logic              rd_cfg,
    output cfg_t              live_o,
    output logic              xtal_o,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - CFG_W;

    typedef struct packed {
        cfg_t pend;
        logic pend_vld;
        cfg_t live;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stage_en) begin
            s_d.pend     = cfg_t'(wcfg);
            s_d.pend_vld = 1'b1;
        end else if (commit_en) begin
            s_d.live     = s_q.pend;
            s_d.pend     = '0;
            s_d.pend_vld = 1'b0;
        end else if (drop_en) begin
            s_d.pend     = '0;
            s_d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign live_o = s_q.live;
    assign xtal_o = (s_q.live.osc == OSC_XTAL);
    assign rdata  = (rd_en && rd_cfg) ? {{PAD_W{1'b0}}, s_q.live} : '0;

    // R3: a commit always has a staged value behind it
    p_commit_needs_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> s_q.pend_vld);

endmodule

// File: rtl/keyed_clk_cfg.sv
module keyed_clk_cfg
    import kcg_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h24,
    parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'h28,
    parameter logic [DATA_W-1:0] KEY_A_VAL  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_B_VAL  = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        osc_sel,
    output logic              ext_clk_en,
    output logic              xtal_sel,
    output logic              seq_err
);

    logic sel_key_a, sel_cfg, sel_key_b, key_a_ok, key_b_ok;
    logic stage_en, commit_en, drop_en;
    cfg_t live;

    kcg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KEY_A_ADDR(KEY_A_ADDR), .CFG_ADDR(CFG_ADDR), .KEY_B_ADDR(KEY_B_ADDR),
        .KEY_A_VAL(KEY_A_VAL), .KEY_B_VAL(KEY_B_VAL)
    ) u_dec (
        .addr(addr), .wdata(wdata),
        .sel_key_a(sel_key_a), .sel_cfg(sel_cfg), .sel_key_b(sel_key_b),
        .key_a_ok(key_a_ok), .key_b_ok(key_b_ok)
    );

    kcg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .sel_key_a(sel_key_a), .sel_cfg(sel_cfg), .sel_key_b(sel_key_b),
        .key_a_ok(key_a_ok), .key_b_ok(key_b_ok),
        .stage_en(stage_en), .commit_en(commit_en), .drop_en(drop_en),
        .err_o(seq_err)
    );

    kcg_store #(.DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .stage_en(stage_en), .commit_en(commit_en), .drop_en(drop_en),
        .wcfg(wdata[CFG_W-1:0]),
        .rd_en(rd_en), .rd_cfg(sel_cfg),
        .live_o(live), .xtal_o(xtal_sel), .rdata(rdata)
    );

    assign osc_sel    = live.osc;
    assign ext_clk_en = live.ext_en;

    // R3: outputs move only after a correct closing key write
    p_commit_only_on_key_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == KEY_B_ADDR && wdata == KEY_B_VAL) |=> $stable({ext_clk_en, osc_sel}));

    // R4: an aborting write never alters the setting
    p_abort_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $stable({ext_clk_en, osc_sel}));

    // R6: reserved bits never read as one
    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CFG_W] == '0);

    // R9: readback agrees with the driven outputs
    p_readback_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CFG_ADDR) |-> rdata[CFG_W-1:0] == {ext_clk_en, osc_sel});

    // R9: key addresses read as zero
    p_key_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == KEY_A_ADDR || addr == KEY_B_ADDR) |-> rdata == '0);

    // R8: crystal flag implies the crystal code
    p_xtal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_sel |-> osc_sel == 2'b10);

endmodule

// File: tb/tb_keyed_clk_cfg.sv
`timescale 1ns/1ps
module tb_keyed_clk_cfg;

    localparam logic [7:0] KA = 8'h20;
    localparam logic [7:0] CF = 8'h24;
    localparam logic [7:0] KB = 8'h28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] osc_sel;
    logic       ext_clk_en, xtal_sel, seq_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    keyed_clk_cfg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .osc_sel(osc_sel), .ext_clk_en(ext_clk_en),
        .xtal_sel(xtal_sel), .seq_err(seq_err)
    );

    // behavioural reference: 0 idle, 1 opened, 2 holding a value
    int         m_step = 0;
    int         m_hold = 0;
    int         m_cfg  = 0;
    bit         m_err  = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step <= 0; m_hold <= 0; m_cfg <= 0; m_err <= 0;
        end else begin
            m_err <= 0;
            if (wr_en) begin
                if (m_step == 0) begin
                    if (addr == KA && wdata != 8'hAA) m_err <= 1;
                    else if (addr == KA)              m_step <= 1;
                    else if (addr == CF || addr == KB) m_err <= 1;
                end else if (m_step == 1) begin
                    if (addr == CF) begin
                        m_hold <= wdata % 8;
                        m_step <= 2;
                    end else begin
                        m_err <= 1; m_step <= 0;
                    end
                end else begin
                    if (addr == KB && wdata == 8'h55) m_cfg <= m_hold;
                    else m_err <= 1;
                    m_step <= 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R3 osc_sel", osc_sel, m_cfg % 4);
            chk("R7 ext_clk_en", ext_clk_en, (m_cfg / 4) % 2);
            chk("R8 xtal_sel", xtal_sel, (m_cfg % 4) == 2);
            chk("R5 seq_err", seq_err, m_err);
            chk("R9 rdata", rdata, (rd_en && addr == CF) ? m_cfg : 0);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
        #2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 8'h00;
    endtask

    task automatic unlock(input logic [7:0] v);
        wr(KA, 8'hAA); wr(CF, v); wr(KB, 8'h55);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(CF, v);
        chk("R1 reset readback", v, 0);
        chk("R1 reset osc", osc_sel, 0);
        chk("R1 reset err", seq_err, 0);

        // R6 R7 R8 full sequence, reserved bits set
        unlock(8'hFE);
        chk("R3 committed ext", ext_clk_en, 1);
        chk("R8 crystal flag", xtal_sel, 1);
        rd(CF, v);
        chk("R6 reserved read zero", v, 8'h06);

        // R10 idle gaps inside the sequence
        wr(KA, 8'hAA); idle(3); wr(CF, 8'h01); idle(4);
        chk("R10 staged not live", osc_sel, 2);
        wr(KB, 8'h55);
        chk("R10 commit after gaps", osc_sel, 1);
        chk("R7 ext off", ext_clk_en, 0);
        chk("R8 code 01 internal", xtal_sel, 0);

        // R2 guarded write without opening key
        wr(CF, 8'h07);
        chk("R2 unkeyed err", seq_err, 1);
        idle(1);
        chk("R5 err one cycle", seq_err, 0);
        rd(CF, v);
        chk("R2 unkeyed no change", v, 8'h01);

        // R4 stray write after opening key, then late closing key
        wr(KA, 8'hAA); wr(8'h30, 8'h12);
        chk("R4 stray after open err", seq_err, 1);
        wr(CF, 8'h06);
        chk("R4 guarded after abort err", seq_err, 1);
        wr(KB, 8'h55);
        chk("R12 stray closing key err", seq_err, 1);
        chk("R4 no commit", osc_sel, 1);

        // R4 wrong closing value discards
        wr(KA, 8'hAA); wr(CF, 8'h06); wr(KB, 8'h54);
        chk("R4 wrong close err", seq_err, 1);
        chk("R4 discarded", ext_clk_en, 0);
        wr(KB, 8'h55);
        chk("R4 no revival", osc_sel, 1);

        // R4 other address while holding
        wr(KA, 8'hAA); wr(CF, 8'h03); wr(8'h44, 8'h55);
        chk("R4 held then stray", seq_err, 1);
        chk("R4 held dropped", osc_sel, 1);

        // R11 unrelated writes while idle
        wr(8'h00, 8'hFF); wr(8'hFC, 8'hAA);
        chk("R11 no err", seq_err, 0);
        chk("R11 no change", osc_sel, 1);

        // R12 wrong opening value
        wr(KA, 8'hAB);
        chk("R12 wrong open err", seq_err, 1);

        // R9 key and foreign reads, rd_en low
        rd(KA, v); chk("R9 key a reads zero", v, 0);
        rd(KB, v); chk("R9 key b reads zero", v, 0);
        @(negedge clk); addr = CF; #2;
        chk("R9 no rd_en zero", rdata, 0);

        // R8 codes 11 and 00, back-to-back sequences
        unlock(8'h03);
        chk("R8 code 11 internal", xtal_sel, 0);
        chk("R8 code 11 value", osc_sel, 3);
        unlock(8'h04);
        chk("R7 ext on", ext_clk_en, 1);
        chk("R8 code 00 internal", xtal_sel, 0);
        unlock(8'h02);
        chk("R8 code 10 crystal", xtal_sel, 1);
        chk("R7 ext cleared", ext_clk_en, 0);

        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule